// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This unit sits beside a NAND flash controller and turns four condition signals into one interrupt line. The four conditions are: the transfer FIFO has drained, the FIFO has filled, the transfer counter has reached zero, and the flash ready/busy pin has returned high. The ready/busy return marks three moments: read data is ready after the address phase, a program is complete, or an erase is complete.

Each condition is caught on its rising edge and held in a sticky status bit. Software writes a mask to choose which bits may raise the interrupt. The masked bits are ORed into a single active-low request. When the request arrives, software reads the status word to find the cause. It then clears the bits it has handled by writing ones to them. A soft reset input clears every pending event in one step and leaves the mask as it is.

The ready/busy pin is asynchronous to the clock, so it is synchronized before its edge is taken. The three other conditions come from logic that runs on the same clock.

Top module: `flash_irq_status`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the status word reads 0, the mask reads 0 and `irq_n` is 1.
- R2: Word address 0 is the status word: ready event at bit 0, counter-zero at bit 1, FIFO-full at bit 2, FIFO-empty at bit 3, bits 31 to 4 zero. Address 1 is the mask, at bits 3 to 0 with the upper bits zero, in the same bit order as the status word. Addresses 2 and 3 read 0. `bus_rdata` carries data only while `bus_sel`=1 and `bus_wr`=0 and is 0 otherwise. A write to address 1 replaces the mask, and the mask holds its value at all other times.
- R3: A 0-to-1 change on `fifo_empty`, `fifo_full` or `cnt_zero` sets the matching status bit at the next rising clock edge. The bit then stays 1 until it is cleared. While the condition stays high after a clear, the bit is not set again.
- R4: When `rdy_busy_pin` rises, the ready bit (bit 0) is still 0 after the second rising clock edge and is 1 after the third rising clock edge. Holding the pin high, or letting it fall, sets nothing.
- R5: `irq_n` is 0 exactly when some status bit and its mask bit are both 1. It follows mask and status changes in the same cycle.
- R6: A write to address 0 clears each status bit whose `bus_wdata` bit is 1. Bits written with 0 keep their value.
- R7: If a set and a write-one-to-clear reach the same status bit at the same clock edge, the bit ends up 1.
- R8: `soft_clr` high at a clock edge clears all status bits, and this takes priority over a set at that edge. The mask is not changed.
- R9: A condition input, or the ready/busy pin, that is already high when `rst` is released raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| soft_clr | input | 1 | Soft reset: clears all pending events |
| fifo_empty | input | 1 | FIFO empty condition, active high |
| fifo_full | input | 1 | FIFO full condition, active high |
| cnt_zero | input | 1 | Transfer counter at zero, active high |
| rdy_busy_pin | input | 1 | Asynchronous ready/busy pin, 1 = ready |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 4 | Write data: clear bits or new mask |
| bus_rdata | output | 32 | Read data, combinational |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The hardest case to reach is a new event edge that lands on the same clock edge as a write-one-to-clear of that same bit. The stimulus produces it by letting the counter-zero condition fall back low, waiting until its edge history has settled, and then raising it and starting the clearing write at the same falling clock edge, so both act on the next rising edge. Soft reset against a simultaneous set is produced the same way. The synchronizer delay on the ready pin is pinned by reading the status word between the second and third rising edges after the pin rises.

// File: rtl/fis_pkg.sv
package fis_pkg;

    localparam int N_EV    = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int N_LEVEL = 3;

    localparam int EV_READY = 0;
    localparam int EV_CNT   = 1;
    localparam int EV_FULL  = 2;
    localparam int EV_EMPTY = 3;

    typedef logic [N_EV-1:0]    ev_vec_t;
    typedef logic [DATA_W-1:0]  word_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1
    } reg_addr_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        ev_vec_t           wdata;
    } bus_req_t;

    function automatic word_t widen(input ev_vec_t v);
        word_t w;
        w = '0;
        w[N_EV-1:0] = v;
        return w;
    endfunction

    function automatic ev_vec_t gather(input logic rdy_rise,
                                       input logic [N_LEVEL-1:0] lvl_rise);
        ev_vec_t v;
        v = '0;
        v[EV_READY] = rdy_rise;
        v[EV_CNT]   = lvl_rise[0];
        v[EV_FULL]  = lvl_rise[1];
        v[EV_EMPTY] = lvl_rise[2];
        return v;
    endfunction

endpackage

// File: rtl/fis_rdy_sync.sv
module fis_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b1;
                    else     chain_q[s] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b1;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

    p_rdy_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fis_level_edge.sv
module fis_level_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) prev_q[i] <= 1'b1;
                else     prev_q[i] <= cond_i[i];
            end
            assign rise_o[i] = cond_i[i] & ~prev_q[i];

            p_lvl_pulse_r3: assert property (@(posedge clk) disable iff (rst)
                rise_o[i] |=> !rise_o[i]);
        end
    endgenerate

endmodule

// File: rtl/fis_event_bank.sv
module fis_event_bank
    import fis_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    soft_clr,
    input  ev_vec_t set_i,
    input  ev_vec_t clr_i,
    output ev_vec_t status_o
);
    ev_vec_t status_q;

    always_ff @(posedge clk) begin
        if (rst)           status_q <= '0;
        else if (soft_clr) status_q <= '0;
        else               status_q <= (status_q & ~clr_i) | set_i;
    end

    assign status_o = status_q;

    p_soft_clr_r8: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> status_o == '0);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && (set_i != '0)) |=> ((status_o & $past(set_i)) == $past(set_i)));

    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && ((clr_i & ~set_i) != '0)) |=> ((status_o & $past(clr_i & ~set_i)) == '0));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !soft_clr |=> (($past(status_o) & ~$past(clr_i) & ~status_o) == '0));

endmodule

// File: rtl/fis_regfile.sv
module fis_regfile
    import fis_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req_i,
    input  ev_vec_t  status_i,
    output ev_vec_t  mask_o,
    output ev_vec_t  clr_o,
    output word_t    rdata_o
);
    ev_vec_t mask_q;
    logic    wr_status;
    logic    wr_mask;
    logic    rd_en;

    assign wr_status = req_i.sel & req_i.wr & (req_i.addr == REG_STATUS);
    assign wr_mask   = req_i.sel & req_i.wr & (req_i.addr == REG_MASK);
    assign rd_en     = req_i.sel & ~req_i.wr;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (wr_mask) mask_q <= req_i.wdata;
    end

    assign clr_o  = wr_status ? req_i.wdata : '0;
    assign mask_o = mask_q;

    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            case (req_i.addr)
                REG_STATUS: rdata_o = widen(status_i);
                REG_MASK:   rdata_o = widen(mask_q);
                default:    rdata_o = '0;
            endcase
        end
    end

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_i.sel && req_i.wr && req_i.addr == REG_MASK) |=> $stable(mask_o));

    p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
        (req_i.sel && req_i.wr && req_i.addr == REG_MASK) |=> mask_o == $past(req_i.wdata));

endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
    import fis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    input  logic              cnt_zero,
    input  logic              rdy_busy_pin,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_EV-1:0]   bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    logic                 rdy_rise;
    logic [N_LEVEL-1:0]   lvl_cond;
    logic [N_LEVEL-1:0]   lvl_rise;
    ev_vec_t              set_vec;
    ev_vec_t              clr_vec;
    ev_vec_t              status;
    ev_vec_t              mask;
    bus_req_t             req;

    assign lvl_cond = {fifo_empty, fifo_full, cnt_zero};
    assign req      = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    fis_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
        .clk       (clk),
        .rst       (rst),
        .pin_async (rdy_busy_pin),
        .rise_o    (rdy_rise)
    );

    fis_level_edge #(.N(N_LEVEL)) u_lvl (
        .clk    (clk),
        .rst    (rst),
        .cond_i (lvl_cond),
        .rise_o (lvl_rise)
    );

    assign set_vec = gather(rdy_rise, lvl_rise);

    fis_event_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (soft_clr),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    fis_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .status_i (status),
        .mask_o   (mask),
        .clr_o    (clr_vec),
        .rdata_o  (bus_rdata)
    );

    assign irq_n = ~(|(status & mask));

    p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> irq_n);

    p_irq_open_r5: assert property (@(posedge clk) disable iff (rst)
        ((mask == '1) && (status != '0)) |-> !irq_n);

    p_irq_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> irq_n);

endmodule

// File: tb/test_flash_irq_status.sv
module test_flash_irq_status;

    logic        clk = 1'b0;
    logic        rst;
    logic        soft_clr;
    logic        fifo_empty, fifo_full, cnt_zero, rdy_busy_pin;
    logic        bus_sel, bus_wr;
    logic [1:0]  bus_addr;
    logic [3:0]  bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_irq_status i_flash_irq_status (
        .clk(clk), .rst(rst), .soft_clr(soft_clr),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .cnt_zero(cnt_zero),
        .rdy_busy_pin(rdy_busy_pin),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    typedef struct packed {
        logic [2:0] cond;
        logic [3:0] mask;
        logic [3:0] exp_st;
        logic       exp_irq_n;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'b001, 4'b0000, 4'b0010, 1'b1},
        '{3'b001, 4'b0010, 4'b0010, 1'b0},
        '{3'b010, 4'b0010, 4'b0100, 1'b1},
        '{3'b010, 4'b0100, 4'b0100, 1'b0},
        '{3'b100, 4'b1000, 4'b1000, 1'b0},
        '{3'b111, 4'b0001, 4'b1110, 1'b1},
        '{3'b111, 4'b1111, 4'b1110, 1'b0},
        '{3'b101, 4'b0100, 4'b1010, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [3:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_cond(input logic [2:0] c);
        cnt_zero = c[0]; fifo_full = c[1]; fifo_empty = c[2];
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; soft_clr = 1'b0;
        fifo_empty = 0; fifo_full = 0; cnt_zero = 0; rdy_busy_pin = 0;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        tick(3);
        bus_read(2'd0, rd); check("R1 status in reset", rd, 0);
        check("R1 irq_n in reset", {31'b0, irq_n}, 1);
        rst = 1'b0;
        tick(1);
        bus_read(2'd0, rd); check("R1 status after reset", rd, 0);
        bus_read(2'd1, rd); check("R1 mask after reset", rd, 0);
        check("R1 irq_n after reset", {31'b0, irq_n}, 1);

        // Table walk: R2 bit layout, R3 level sets, R5 masking, R6 clear
        for (int k = 0; k < 8; k++) begin
            bus_write(2'd1, VECS[k].mask);
            bus_read(2'd1, rd); check("R2 mask readback", rd, {28'b0, VECS[k].mask});
            set_cond(VECS[k].cond);
            tick(1);
            bus_read(2'd0, rd); check("R3 R2 status layout", rd, {28'b0, VECS[k].exp_st});
            check("R5 irq_n", {31'b0, irq_n}, {31'b0, VECS[k].exp_irq_n});
            set_cond(3'b000);
            bus_write(2'd0, 4'hF);
            bus_read(2'd0, rd); check("R6 clear all", rd, 0);
        end
        bus_write(2'd1, 4'h0);

        // R3: held condition does not re-raise after clear
        cnt_zero = 1; tick(1);
        bus_read(2'd0, rd); check("R3 set on rise", rd, 32'h2);
        bus_write(2'd0, 4'h2); tick(3);
        bus_read(2'd0, rd); check("R3 held no re-raise", rd, 0);
        cnt_zero = 0; tick(2);

        // R4: ready pin synchronizer latency and edge-only behaviour
        rdy_busy_pin = 1; tick(2);
        bus_read(2'd0, rd); check("R4 not yet after 2 edges", rd, 0);
        tick(1);
        bus_read(2'd0, rd); check("R4 set after 3 edges", rd, 32'h1);
        tick(4);
        bus_write(2'd0, 4'h1); tick(4);
        bus_read(2'd0, rd); check("R4 held high no set", rd, 0);
        rdy_busy_pin = 0; tick(4);
        bus_read(2'd0, rd); check("R4 fall no set", rd, 0);
        rdy_busy_pin = 1; tick(3);
        bus_read(2'd0, rd); check("R4 second rise", rd, 32'h1);
        bus_write(2'd0, 4'h1);

        // R6: partial write-one-to-clear
        set_cond(3'b111); tick(1); set_cond(3'b000); tick(1);
        bus_write(2'd0, 4'h0);
        bus_read(2'd0, rd); check("R6 zero write keeps", rd, 32'hE);
        bus_write(2'd0, 4'h4);
        bus_read(2'd0, rd); check("R6 single clear", rd, 32'hA);
        bus_write(2'd0, 4'hA);
        bus_read(2'd0, rd); check("R6 rest cleared", rd, 0);

        // R7: set and clear on the same edge
        cnt_zero = 1;
        bus_write(2'd0, 4'h2);
        bus_read(2'd0, rd); check("R7 set wins", rd, 32'h2);
        bus_write(2'd0, 4'h2);
        bus_read(2'd0, rd); check("R7 later clear", rd, 0);
        cnt_zero = 0; tick(2);

        // R5: mask changes act on irq_n in the same cycle
        bus_write(2'd1, 4'h8);
        fifo_empty = 1; tick(1); fifo_empty = 0;
        check("R5 unmasked low", {31'b0, irq_n}, 0);
        bus_write(2'd1, 4'h0);
        check("R5 masked high", {31'b0, irq_n}, 1);
        bus_write(2'd1, 4'h8);
        check("R5 unmasked again", {31'b0, irq_n}, 0);
        bus_write(2'd0, 4'h8);
        check("R5 cleared high", {31'b0, irq_n}, 1);

        // R8: soft reset
        bus_write(2'd1, 4'hF);
        set_cond(3'b111); tick(1); set_cond(3'b000);
        soft_clr = 1; tick(1); soft_clr = 0;
        bus_read(2'd0, rd); check("R8 soft clears", rd, 0);
        bus_read(2'd1, rd); check("R8 mask kept", rd, 32'hF);
        check("R8 irq_n", {31'b0, irq_n}, 1);
        fifo_full = 1; soft_clr = 1; tick(1); soft_clr = 0; tick(2);
        bus_read(2'd0, rd); check("R8 soft beats set", rd, 0);
        fifo_full = 0; tick(1);

        // R2: unmapped addresses and idle bus
        cnt_zero = 1; tick(1); cnt_zero = 0;
        bus_read(2'd2, rd); check("R2 addr 2 zero", rd, 0);
        bus_read(2'd3, rd); check("R2 addr 3 zero", rd, 0);
        bus_sel = 0; bus_wr = 0; bus_addr = 2'd0; #1;
        check("R2 idle bus zero", bus_rdata, 0);
        bus_read(2'd0, rd); check("R2 status present", rd, 32'h2);

        // R9: conditions high across reset release
        fifo_empty = 1; rdy_busy_pin = 1; rst = 1; tick(3);
        rst = 0; tick(5);
        bus_read(2'd0, rd); check("R9 no event at release", rd, 0);
        bus_read(2'd1, rd); check("R9 R1 mask reset", rd, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule